// File: doc/BRIEF.md
# Rational Polyphase Sample-Rate Converter

This block changes the sample rate of a single stream by a fixed rational factor L/M. In concept the stream is raised by L (zeros placed between samples), low-pass filtered, and lowered by M, keeping every M-th point. The hardware never builds that raised stream. A phase register keeps the position inside the virtual L-times grid. It advances by M after each output. Each time it passes L-1 it drops by L, and one fresh input sample is pulled into a short history. So one merged filter serves both the anti-imaging and the anti-aliasing role, and only the coefficient phase that an output really needs is evaluated.

Every output is computed by one multiplier-accumulator in TAPS cycles. The filter uses the prototype coefficients h[phase + k*L] against the TAPS most recent inputs, and the sum is rounded and clamped to the sample width. Both stream sides use valid/ready. A sample moves when valid and ready are both high on a rising clock edge. The block raises in_ready only while it is waiting for a sample that the current phase needs, and it never raises in_ready while a result is held. An output that is not taken stays presented, unchanged, for as long as out_ready is low. The prototype is a symmetric triangle that the block computes at elaboration time, so no coefficient storage needs to be loaded.

Top module: `ratio_resampler`

## Requirements
- R1: Counting outputs from q = 0 after reset, exactly floor(q*M/L)+1 input samples have been accepted before output q is accepted, and the coefficient phase of output q is (q*M) mod L; this holds for L > M and for M > L.
- R2: Output q equals the clamped, rounded value of sum over n = 0..N-1 of h[n]*u[q*M-n], where N = L*TAPS, u[j] = x[j/L] when j is a multiple of L and 0 otherwise, samples before the first input after reset are 0, and h[n] = CSCALE*(n+1) for n < N/2 and CSCALE*(N-n) otherwise.
- R3: The accumulated sum is rounded by adding 2^(FRAC-1) and shifting arithmetically right by FRAC, then clamped to the range -2^(DW-1) to 2^(DW-1)-1.
- R4: While out_valid is high and out_ready is low, out_valid stays high, out_data does not change, and in_ready stays low.
- R5: in_ready is high only while the phase has a wrap pending and no result is held; an output that needs no new sample is produced with in_ready low throughout, and when M > L several samples are taken back to back before one output.
- R6: Reset drops out_valid, raises in_ready, clears the sample history, and restarts the phase so that the first accepted sample feeds output 0.
- R7: out_valid rises exactly TAPS+1 cycles after the last handshake (input or output) that the output waited for.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block will take the offered sample this edge |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_data | output | DW | Signed, rounded and clamped result |

## Verification
The default 5/2 instance first receives a mixed-sign ramp-like sequence. Each output is compared with a zero-stuff, full-filter, keep-every-second model, and the number of inputs taken is checked at each output. Together these separate the wrong phase from a wrong consume count. A run of full-scale positive then full-scale negative samples drives both clamps and checks rounding at the extremes. A single impulse with the output stalled checks the hold rule, shows that in_ready stays low for outputs that need no new sample, and checks the latency. A reset in the middle of the stream, followed by a second impulse, separates a cleared history from a stale one. A second instance with M > L (3/7) is run with an open stream, so the burst consumption pattern 1, 2, 2, 3, ... can be checked.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  typedef enum logic [1:0] {
    ST_STEP = 2'd0,
    ST_MAC  = 2'd1,
    ST_OUT  = 2'd2
  } rs_state_e;

  // Symmetric triangular prototype of length len, peak len/2 * scale.
  function automatic int proto_coef(input int n, input int len, input int scale);
    if (n < len / 2) return (n + 1) * scale;
    else             return (len - n) * scale;
  endfunction

endpackage

// File: rtl/rs_phase_ctrl.sv
module rs_phase_ctrl
  import rsmp_pkg::*;
#(
  parameter int L    = 5,
  parameter int M    = 2,
  parameter int TAPS = 4,
  localparam int PW  = $clog2(L + M),
  localparam int KW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          take,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          mac_en,
  output logic          mac_first,
  output logic [PW-1:0] phase,
  output logic [KW-1:0] tap
);

  rs_state_e     state_q;
  logic [PW-1:0] phase_q;
  logic [KW-1:0] tap_q;
  logic          wrap_due;

  assign wrap_due  = phase_q >= PW'(L);
  assign in_ready  = (state_q == ST_STEP) && wrap_due;
  assign take      = in_ready && in_valid;
  assign out_valid = (state_q == ST_OUT);
  assign mac_en    = (state_q == ST_MAC);
  assign mac_first = (tap_q == '0);
  assign phase     = phase_q;
  assign tap       = tap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_STEP;
      phase_q <= PW'(L);
      tap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_STEP: begin
          if (wrap_due) begin
            if (in_valid) phase_q <= phase_q - PW'(L);
          end else begin
            state_q <= ST_MAC;
            tap_q   <= '0;
          end
        end
        ST_MAC: begin
          if (tap_q == KW'(TAPS - 1)) state_q <= ST_OUT;
          else                        tap_q   <= tap_q + 1'b1;
        end
        ST_OUT: begin
          if (out_ready) begin
            phase_q <= phase_q + PW'(M);
            state_q <= ST_STEP;
          end
        end
        default: state_q <= ST_STEP;
      endcase
    end
  end

endmodule

// File: rtl/rs_history.sv
module rs_history #(
  parameter int DW   = 16,
  parameter int TAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] hist [TAPS]
);

  logic signed [DW-1:0] line_q [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) line_q[i] <= '0;
    end else if (shift) begin
      line_q[0] <= din;
      for (int i = 1; i < TAPS; i++) line_q[i] <= line_q[i-1];
    end
  end

  assign hist = line_q;

endmodule

// File: rtl/rs_mac.sv
module rs_mac
  import rsmp_pkg::*;
#(
  parameter int L      = 5,
  parameter int TAPS   = 4,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int FRAC   = 12,
  parameter int CSCALE = 1024,
  parameter int PW     = 3,
  parameter int KW     = 2,
  localparam int NCOEF = L * TAPS,
  localparam int CIW   = $clog2(NCOEF),
  localparam int AW    = DW + CW + $clog2(TAPS + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mac_en,
  input  logic                 mac_first,
  input  logic [PW-1:0]        phase,
  input  logic [KW-1:0]        tap,
  input  logic signed [DW-1:0] hist [TAPS],
  output logic signed [DW-1:0] result
);

  localparam logic signed [AW-1:0] HALF   = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] SAT_HI = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] SAT_LO = -(AW'(1) <<< (DW - 1));

  logic signed [CW-1:0]    crom [NCOEF];
  logic [CIW-1:0]          cidx;
  logic signed [DW-1:0]    sample;
  logic signed [CW-1:0]    coef;
  logic signed [DW+CW-1:0] prod;
  logic signed [AW-1:0]    acc_q, acc_base, rnd, shf;

  for (genvar g = 0; g < NCOEF; g++) begin : g_rom
    assign crom[g] = CW'(proto_coef(g, NCOEF, CSCALE));
  end

  assign cidx     = CIW'(phase) + CIW'(32'(tap) * L);
  assign sample   = hist[tap];
  assign coef     = crom[cidx];
  assign prod     = sample * coef;
  assign acc_base = mac_first ? AW'(0) : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (mac_en) acc_q <= acc_base + AW'(prod);
  end

  always_comb begin
    rnd = acc_q + HALF;
    shf = rnd >>> FRAC;
    if (shf > SAT_HI)      result = SAT_HI[DW-1:0];
    else if (shf < SAT_LO) result = SAT_LO[DW-1:0];
    else                   result = shf[DW-1:0];
  end

endmodule

// File: rtl/ratio_resampler.sv
module ratio_resampler
  import rsmp_pkg::*;
#(
  parameter int L      = 5,
  parameter int M      = 2,
  parameter int TAPS   = 4,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int FRAC   = 12,
  parameter int CSCALE = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data
);

  localparam int PW = $clog2(L + M);
  localparam int KW = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic                 take, mac_en, mac_first;
  logic [PW-1:0]        phase_w;
  logic [KW-1:0]        tap_w;
  logic signed [DW-1:0] hist_w [TAPS];

  rs_phase_ctrl #(.L(L), .M(M), .TAPS(TAPS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .take      (take),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .phase     (phase_w),
    .tap       (tap_w)
  );

  rs_history #(.DW(DW), .TAPS(TAPS)) hist_i (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (take),
    .din   (in_data),
    .hist  (hist_w)
  );

  rs_mac #(
    .L(L), .TAPS(TAPS), .DW(DW), .CW(CW), .FRAC(FRAC),
    .CSCALE(CSCALE), .PW(PW), .KW(KW)
  ) mac_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .phase     (phase_w),
    .tap       (tap_w),
    .hist      (hist_w),
    .result    (out_data)
  );

endmodule

// File: rtl/ratio_resampler_chk.sv
module ratio_resampler_chk #(
  parameter int L    = 5,
  parameter int M    = 2,
  parameter int TAPS = 4,
  parameter int DW   = 16,
  parameter int PW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [PW-1:0] phase
);

  localparam int CNW = $clog2(TAPS + 3) + 1;
  logic [CNW-1:0] since_hs;

  // cycles since the last handshake on either side, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)                                          since_hs <= '0;
    else if ((in_valid && in_ready) || (out_valid && out_ready)) since_hs <= '0;
    else if (since_hs != '1)                             since_hs <= since_hs + 1'b1;
  end

  assert_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phase < PW'(L)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_hs == CNW'(TAPS + 1)));

endmodule

bind ratio_resampler ratio_resampler_chk #(
  .L(L), .M(M), .TAPS(TAPS), .DW(DW), .PW($clog2(L + M))
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .phase     (phase_w)
);

// File: tb/ratio_resampler_tb_top.sv
module ratio_resampler_tb_top;

  localparam int L = 5, M = 2, TAPS = 4, DW = 16, FRAC = 12, CSCALE = 1024;
  localparam int N = L * TAPS;

  localparam logic signed [15:0] STIM [16] = '{
    16'sd300, 16'sd812, -16'sd455, 16'sd17, -16'sd799, 16'sd640, 16'sd1, -16'sd3,
    16'sd555, -16'sd128, 16'sd777, -16'sd600, 16'sd90, 16'sd333, -16'sd51, 16'sd700
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n, in_valid, in_ready, out_valid, out_ready;
  logic signed [DW-1:0] in_data, out_data;
  logic                 rst2_n, in_ready2, out_valid2;
  logic signed [DW-1:0] out_data2;

  ratio_resampler #(.L(L), .M(M), .TAPS(TAPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  ratio_resampler #(.L(3), .M(7), .TAPS(2)) dut_wide_i (
    .clk(clk), .rst_n(rst2_n), .in_valid(1'b1), .in_ready(in_ready2),
    .in_data(16'sd0), .out_valid(out_valid2), .out_ready(1'b1),
    .out_data(out_data2)
  );

  int checks = 0, fails = 0;
  int xs [32];
  int nx;
  bit col_en = 0;
  int ic, oc;
  int got [64], icat [64];
  int ic2 = 0, oc2 = 0;
  int rec2 [8];

  // collector for the main instance
  always @(negedge clk) begin
    if (!col_en) begin
      ic = 0; oc = 0;
    end else begin
      if (in_valid && in_ready) ic++;
      if (out_valid && out_ready && oc < 64) begin
        got[oc] = out_data; icat[oc] = ic; oc++;
      end
    end
  end

  // consumption recorder for the M > L instance
  always @(negedge clk) begin
    if (rst2_n) begin
      if (in_ready2) ic2++;
      if (out_valid2) begin
        if (oc2 < 8) rec2[oc2] = ic2;
        oc2++;
      end
    end
  end

  function automatic int hcoef(int n);
    return (n < N / 2) ? (n + 1) * CSCALE : (N - n) * CSCALE;
  endfunction

  function automatic int model(int q);
    longint s = 0, r;
    for (int n = 0; n < N; n++) begin
      int j = q * M - n;
      if (j >= 0 && (j % L) == 0 && (j / L) < nx) s += longint'(hcoef(n)) * xs[j / L];
    end
    r = (s + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // entered at a negedge, returns at the negedge after the accepting edge
  task automatic send(int v);
    in_valid = 1'b1;
    in_data  = DW'(v);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_stream(int nout);
    out_ready = 1'b1;
    col_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < nx; i++) send(xs[i]);
    while (oc < nout) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(oc == nout, "R1 output count", oc, nout);
    for (int q = 0; q < nout; q++) begin
      chk(got[q] == model(q), "R2 R3 output value", got[q], model(q));
      chk(icat[q] == (q * M) / L + 1, "R1 inputs before output", icat[q], (q * M) / L + 1);
    end
    col_en = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    summary();
  end

  initial begin
    int lat, first;
    bit seen_ir, bad;
    rst_n = 0; rst2_n = 0; in_valid = 0; in_data = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R6 out_valid in reset", out_valid, 0);
    rst_n = 1; rst2_n = 1;
    @(negedge clk);
    chk(!out_valid, "R6 out_valid after reset", out_valid, 0);
    chk(in_ready, "R6 in_ready after reset", in_ready, 1);

    // table walk: mixed-sign stream, 40 outputs from 16 inputs
    for (int i = 0; i < 16; i++) xs[i] = STIM[i];
    nx = 16;
    run_stream(40);

    // saturation: full-scale positive then negative
    do_reset();
    for (int i = 0; i < 4; i++) xs[i] = 32767;
    for (int i = 4; i < 8; i++) xs[i] = -32768;
    nx = 8;
    run_stream(20);
    chk(got[6] == 32767, "R3 positive clamp", got[6], 32767);
    chk(got[17] == -32768, "R3 negative clamp", got[17], -32768);

    // impulse with stalled output: hold, latency, no-input output
    do_reset();
    out_ready = 1'b0;
    send(1000);
    lat = 0;
    while (!out_valid && lat < 50) begin @(negedge clk); lat++; end
    chk(lat == TAPS + 1, "R7 latency after input", lat, TAPS + 1);
    first = out_data;
    chk(first == 250, "R2 impulse output 0", first, 250);
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (!out_valid || out_data != first || in_ready) bad = 1;
    end
    chk(!bad, "R4 hold under back-pressure", bad, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    lat = 0; seen_ir = 0;
    while (!out_valid && lat < 50) begin
      if (in_ready) seen_ir = 1;
      @(negedge clk); lat++;
    end
    chk(!seen_ir, "R5 no input for output 1", seen_ir, 0);
    chk(lat == TAPS + 1, "R7 latency after output", lat, TAPS + 1);
    chk(out_data == 750, "R2 impulse output 1", out_data, 750);

    // reset with a result pending clears output and history
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R6 reset drops held result", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R6 in_ready after mid reset", in_ready, 1);
    send(2000);
    lat = 0;
    while (!out_valid && lat < 50) begin @(negedge clk); lat++; end
    chk(out_data == 500, "R6 history cleared", out_data, 500);

    // M > L instance: cumulative consumption floor(7q/3)+1
    chk(oc2 >= 8, "R1 wide outputs", oc2, 8);
    for (int q = 0; q < 8; q++)
      chk(rec2[q] == (q * 7) / 3 + 1, "R1 R5 burst consumption", rec2[q], (q * 7) / 3 + 1);

    summary();
  end

endmodule